// File: doc/BRIEF.md
# Two-Wire Serialized JTAG Adapter

The adapter takes a stream of four-wire JTAG cycle commands and plays each one out on two wires. The first wire is a clock the adapter drives towards the target. The second is a bidirectional data wire. Every JTAG cycle becomes three time slots on the data wire. The TMS value goes in the first slot and the TDI value in the second. In the third slot the adapter releases the wire so that the target can return TDO. The bit it reads back is sent to the host on a response stream, but only when the command asks for it.

While the TAP sits in Run-Test/Idle, the TDI slot carries the target's test clock instead of data. Each command states the test-clock level before the cycle and the level after it, so the adapter keeps no test-clock history. It puts the before level back on the data wire soon after the TMS slot opens. It drives the after level in the middle of the high phase of the TDI slot. When the two levels are the same, no edge appears. Two sideband pins, for mode entry and target reset, are plain outputs. A command can set them without running any slots.

Slot timing is set by the `qlen` input, which is a quarter-slot length Q in system clocks. Each slot is four quarters long. The two low quarters come first and the two high quarters follow.

Top module: `twj_serializer`

## Requirements
- R1: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a cycle is being played out and while a response is still pending. A cycle command (`cmd_sb_only`=0) occupies the 12·Q cycles that follow the accepting edge. Those cycles hold the TMS, TDI and TDO slots in that order, each 4·Q cycles long. Q is `qlen` latched at acceptance, and a value of 0 is treated as 1.
- R2: `wire_clk` is low during the first 2·Q cycles of every slot and high during the last 2·Q cycles. It is high whenever no cycle is being played out.
- R3: When `cmd_rti`=0, the adapter drives the data wire with `wire_oe`=1. `wire_do` carries `cmd_tms` for the whole TMS slot and `cmd_tdi` for the whole TDI slot.
- R4: When `cmd_rti`=1, `wire_do` carries `cmd_tms` in the first Q cycles of the TMS slot and `cmd_tck_pre` in its remaining 3·Q cycles, with `wire_oe`=1.
- R5: When `cmd_rti`=1, `wire_do` carries `cmd_tck_pre` in the first 3·Q cycles of the TDI slot and `cmd_tck_post` in its last Q cycles. An edge therefore appears only when the two bits differ, and never when they are equal.
- R6: During the TDO slot, and whenever no cycle is active, `wire_oe` is 0 and `wire_do` is 0.
- R7: `wire_di` is sampled in the last cycle of the third quarter of the TDO slot, which is cycle 11·Q−1 counting from 0 after acceptance. If `cmd_capture`=1, `rsp_valid` rises on the next cycle with `rsp_tdo` equal to the sampled bit. Both hold until a cycle with `rsp_ready`=1. If `cmd_capture`=0, no response is produced.
- R8: A command with `cmd_sb_only`=1 copies `cmd_sb_test` and `cmd_sb_rst` to `sb_test` and `sb_rst` from the next cycle on. It plays out no slots, so `cmd_ready` is high again on the next cycle. Cycle commands leave both sideband outputs unchanged.
- R9: While reset is applied, `wire_clk`=1, `wire_oe`=0, `rsp_valid`=0, `sb_test`=0 and `sb_rst`=0. `cmd_ready` is high within three cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qlen | input | QW | Quarter-slot length in clocks (0 acts as 1) |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be taken |
| cmd_sb_only | input | 1 | 1: sideband update only, no slots |
| cmd_tms | input | 1 | TMS value of the cycle |
| cmd_tdi | input | 1 | TDI value of the cycle |
| cmd_tck_pre | input | 1 | Test-clock level before the cycle |
| cmd_tck_post | input | 1 | Test-clock level after the cycle |
| cmd_rti | input | 1 | TAP is in Run-Test/Idle for this cycle |
| cmd_capture | input | 1 | Return the TDO bit |
| cmd_sb_test | input | 1 | Mode-entry pin level (sideband commands) |
| cmd_sb_rst | input | 1 | Reset pin level (sideband commands) |
| rsp_valid | output | 1 | TDO bit available |
| rsp_ready | input | 1 | Host takes the TDO bit |
| rsp_tdo | output | 1 | Captured TDO bit |
| wire_clk | output | 1 | Serial clock wire |
| wire_do | output | 1 | Data wire output value |
| wire_oe | output | 1 | Data wire output enable |
| wire_di | input | 1 | Data wire input value |
| sb_test | output | 1 | Mode-entry sideband pin |
| sb_rst | output | 1 | Reset sideband pin |

## Verification
The bench keeps the default QW of 4 and changes the programmed quarter length between 0, 1, 2 and 3. Using 0 exercises the rule that a zero length acts as one. Lengths of 2 and 3 make a quarter boundary that is off by one cycle visible. For each length the bench runs all 64 combinations of TMS, TDI, the two test-clock bits, the idle flag and the capture flag. The bench compares every cycle of every slot against the expected pattern. It drives the correct TDO bit only in the one sampling cycle, so any drift in the sampling point shows up as a wrong response.

// File: rtl/twj_pkg.sv
package twj_pkg;
  localparam int NQUART = 4;

  typedef enum logic [1:0] {
    SLOT_TMS = 2'd0,
    SLOT_TDI = 2'd1,
    SLOT_TDO = 2'd2
  } slot_e;

  typedef struct packed {
    logic tms;
    logic tdi;
    logic tck_pre;
    logic tck_post;
    logic rti;
    logic capture;
  } cyc_cmd_t;
endpackage

// File: rtl/twj_rst_sync.sv
module twj_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/twj_phase.sv
module twj_phase
  import twj_pkg::*;
#(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [QW-1:0] qlen,
  output logic          busy,
  output slot_e         slot,
  output logic [1:0]    quarter,
  output logic          qend
);
  logic          busy_q, busy_d;
  slot_e         slot_q, slot_d;
  logic [1:0]    quart_q, quart_d;
  logic [QW-1:0] cnt_q, cnt_d;
  logic [QW-1:0] qmax_q, qmax_d;
  logic          at_qend;

  assign at_qend = busy_q && (cnt_q == qmax_q);

  always_comb begin
    busy_d  = busy_q;
    slot_d  = slot_q;
    quart_d = quart_q;
    cnt_d   = cnt_q;
    qmax_d  = qmax_q;
    if (start) begin
      busy_d  = 1'b1;
      slot_d  = SLOT_TMS;
      quart_d = 2'd0;
      cnt_d   = '0;
      qmax_d  = (qlen == '0) ? '0 : qlen - 1'b1;
    end else if (busy_q) begin
      if (at_qend) begin
        cnt_d   = '0;
        quart_d = quart_q + 2'd1;
        if (quart_q == 2'(NQUART - 1)) begin
          if (slot_q == SLOT_TDO) busy_d = 1'b0;
          else                    slot_d = slot_e'(slot_q + 2'd1);
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      slot_q  <= SLOT_TMS;
      quart_q <= 2'd0;
      cnt_q   <= '0;
      qmax_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      slot_q  <= slot_d;
      quart_q <= quart_d;
      cnt_q   <= cnt_d;
      qmax_q  <= qmax_d;
    end
  end

  assign busy    = busy_q;
  assign slot    = slot_q;
  assign quarter = quart_q;
  assign qend    = at_qend;

  // R1: slots advance strictly TMS -> TDI -> TDO within one command
  a_r1_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && $past(busy_q) && (slot_q != $past(slot_q))
      |-> (2'(slot_q) == 2'($past(slot_q)) + 2'd1));

  // R1: the quarter counter never passes the latched length
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q <= qmax_q));
endmodule

// File: rtl/twj_line.sv
module twj_line
  import twj_pkg::*;
(
  input  logic       busy,
  input  slot_e      slot,
  input  logic [1:0] quarter,
  input  logic       tms,
  input  logic       tdi,
  input  logic       tck_pre,
  input  logic       tck_post,
  input  logic       rti,
  output logic       wire_clk,
  output logic       wire_do,
  output logic       wire_oe
);
  always_comb begin
    wire_clk = 1'b1;
    wire_do  = 1'b0;
    wire_oe  = 1'b0;
    if (busy) begin
      wire_clk = quarter[1];
      case (slot)
        SLOT_TMS: begin
          wire_oe = 1'b1;
          wire_do = (rti && quarter != 2'd0) ? tck_pre : tms;
        end
        SLOT_TDI: begin
          wire_oe = 1'b1;
          if (rti) wire_do = (quarter == 2'd3) ? tck_post : tck_pre;
          else     wire_do = tdi;
        end
        default: begin
          wire_oe = 1'b0;
          wire_do = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/twj_capture.sv
module twj_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic want,
  input  logic din,
  input  logic rsp_ready,
  output logic rsp_valid,
  output logic rsp_tdo
);
  logic vld_q, vld_d;
  logic bit_q, bit_d;

  always_comb begin
    vld_d = vld_q;
    bit_d = bit_q;
    if (sample && want) begin
      vld_d = 1'b1;
      bit_d = din;
    end else if (rsp_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      bit_q <= bit_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_tdo   = bit_q;

  // R7: a pending response holds its bit until it is taken
  a_r7_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q && !rsp_ready && !sample |=> vld_q && $stable(bit_q));
endmodule

// File: rtl/twj_serializer.sv
module twj_serializer
  import twj_pkg::*;
#(
  parameter int QW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] qlen,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_sb_only,
  input  logic          cmd_tms,
  input  logic          cmd_tdi,
  input  logic          cmd_tck_pre,
  input  logic          cmd_tck_post,
  input  logic          cmd_rti,
  input  logic          cmd_capture,
  input  logic          cmd_sb_test,
  input  logic          cmd_sb_rst,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic          rsp_tdo,
  output logic          wire_clk,
  output logic          wire_do,
  output logic          wire_oe,
  input  logic          wire_di,
  output logic          sb_test,
  output logic          sb_rst
);
  logic       rstn_i;
  logic       accept, start, sb_load;
  logic       busy, qend, sample;
  slot_e      slot;
  logic [1:0] quarter;
  cyc_cmd_t   cmd_q, cmd_d;
  logic [1:0] side_q, side_d;

  twj_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rstn_i)
  );

  assign cmd_ready = !busy && !rsp_valid;
  assign accept    = cmd_valid && cmd_ready;
  assign start     = accept && !cmd_sb_only;
  assign sb_load   = accept && cmd_sb_only;

  always_comb begin
    cmd_d  = cmd_q;
    side_d = side_q;
    if (start) begin
      cmd_d.tms      = cmd_tms;
      cmd_d.tdi      = cmd_tdi;
      cmd_d.tck_pre  = cmd_tck_pre;
      cmd_d.tck_post = cmd_tck_post;
      cmd_d.rti      = cmd_rti;
      cmd_d.capture  = cmd_capture;
    end
    if (sb_load) side_d = {cmd_sb_test, cmd_sb_rst};
  end

  always_ff @(posedge clk or negedge rstn_i) begin
    if (!rstn_i) begin
      cmd_q  <= '0;
      side_q <= 2'b00;
    end else begin
      cmd_q  <= cmd_d;
      side_q <= side_d;
    end
  end

  assign sb_test = side_q[1];
  assign sb_rst  = side_q[0];

  twj_phase #(.QW(QW)) u_phase (
    .clk(clk), .rst_n(rstn_i), .start(start), .qlen(qlen),
    .busy(busy), .slot(slot), .quarter(quarter), .qend(qend)
  );

  twj_line u_line (
    .busy(busy), .slot(slot), .quarter(quarter),
    .tms(cmd_q.tms), .tdi(cmd_q.tdi),
    .tck_pre(cmd_q.tck_pre), .tck_post(cmd_q.tck_post), .rti(cmd_q.rti),
    .wire_clk(wire_clk), .wire_do(wire_do), .wire_oe(wire_oe)
  );

  assign sample = busy && (slot == SLOT_TDO) && (quarter == 2'd2) && qend;

  twj_capture u_cap (
    .clk(clk), .rst_n(rstn_i), .sample(sample), .want(cmd_q.capture),
    .din(wire_di), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_tdo(rsp_tdo)
  );

  // R1: no command is taken while slots are being played out
  a_r1_ready_blocked: assert property (@(posedge clk) disable iff (!rstn_i)
    busy |-> !cmd_ready);

  // R2: the serial clock rests high between commands
  a_r2_clk_rest: assert property (@(posedge clk) disable iff (!rstn_i)
    !busy |-> wire_clk);

  // R5: equal before/after levels give a flat data wire through the TDI slot
  a_r5_no_spurious_edge: assert property (@(posedge clk) disable iff (!rstn_i)
    busy && $past(busy) && (slot == SLOT_TDI) && ($past(slot) == SLOT_TDI)
      && cmd_q.rti && (cmd_q.tck_pre == cmd_q.tck_post)
      |-> $stable(wire_do));

  // R6: the wire is released for the target's reply
  a_r6_release: assert property (@(posedge clk) disable iff (!rstn_i)
    busy && (slot == SLOT_TDO) |-> !wire_oe);

  // R8: sideband pins move only after a sideband command
  a_r8_side_hold: assert property (@(posedge clk) disable iff (!rstn_i)
    !sb_load |=> $stable({sb_test, sb_rst}));
endmodule

// File: tb/sim_twj_serializer.sv
`timescale 1ns/1ps
module sim_twj_serializer;
  localparam int QW = 4;

  logic clk, rst_n;
  logic [QW-1:0] qlen;
  logic cmd_valid, cmd_ready, cmd_sb_only, cmd_tms, cmd_tdi;
  logic cmd_tck_pre, cmd_tck_post, cmd_rti, cmd_capture, cmd_sb_test, cmd_sb_rst;
  logic rsp_valid, rsp_ready, rsp_tdo;
  logic wire_clk, wire_do, wire_oe, wire_di, sb_test, sb_rst;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  twj_serializer #(.QW(QW)) u0 (
    .clk(clk), .rst_n(rst_n), .qlen(qlen),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_sb_only(cmd_sb_only),
    .cmd_tms(cmd_tms), .cmd_tdi(cmd_tdi), .cmd_tck_pre(cmd_tck_pre),
    .cmd_tck_post(cmd_tck_post), .cmd_rti(cmd_rti), .cmd_capture(cmd_capture),
    .cmd_sb_test(cmd_sb_test), .cmd_sb_rst(cmd_sb_rst),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tdo(rsp_tdo),
    .wire_clk(wire_clk), .wire_do(wire_do), .wire_oe(wire_oe), .wire_di(wire_di),
    .sb_test(sb_test), .sb_rst(sb_rst)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  task automatic run_cmd(input logic tms, tdi, tpre, tpost, rti, cap,
                         input int qp, input logic b);
    int qe;
    int bad_clk, bad_rdy, bad_tms, bad_tdi, bad_tdo;
    logic st0, sr0;
    qe = (qp == 0) ? 1 : qp;
    bad_clk = 0; bad_rdy = 0; bad_tms = 0; bad_tdi = 0; bad_tdo = 0;
    @(negedge clk);
    qlen = QW'(qp);
    cmd_sb_only = 1'b0;
    cmd_tms = tms; cmd_tdi = tdi; cmd_tck_pre = tpre; cmd_tck_post = tpost;
    cmd_rti = rti; cmd_capture = cap;
    cmd_sb_test = ~sb_test; cmd_sb_rst = ~sb_rst;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    st0 = sb_test; sr0 = sb_rst;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 12 * qe; k++) begin
      int qt;
      int sl;
      logic exp_do;
      qt = (k / qe) % 4;
      sl = k / (4 * qe);
      wire_di = (k == 11 * qe - 1) ? b : ~b;
      if (wire_clk !== (qt >= 2)) bad_clk++;
      if (cmd_ready !== 1'b0) bad_rdy++;
      if (sl == 0) begin
        exp_do = (rti && qt != 0) ? tpre : tms;
        if (wire_oe !== 1'b1 || wire_do !== exp_do) bad_tms++;
      end else if (sl == 1) begin
        if (rti) exp_do = (qt == 3) ? tpost : tpre;
        else     exp_do = tdi;
        if (wire_oe !== 1'b1 || wire_do !== exp_do) bad_tdi++;
      end else begin
        if (wire_oe !== 1'b0 || wire_do !== 1'b0) bad_tdo++;
      end
      @(negedge clk);
    end
    if (wire_clk !== 1'b1) bad_clk++;
    if (wire_oe !== 1'b0) bad_tdo++;
    check(bad_clk == 0, "R2 clock wave", bad_clk, 0);
    check(bad_rdy == 0, "R1 ready low while busy", bad_rdy, 0);
    check(bad_tms == 0, rti ? "R4 TMS slot" : "R3 TMS slot", bad_tms, 0);
    check(bad_tdi == 0, rti ? "R5 TDI slot" : "R3 TDI slot", bad_tdi, 0);
    check(bad_tdo == 0, "R6 release", bad_tdo, 0);
    check(rsp_valid === cap, "R7 response present", int'(rsp_valid), int'(cap));
    if (cap) check(rsp_tdo === b, "R7 sampled bit", int'(rsp_tdo), int'(b));
    check(sb_test === st0 && sb_rst === sr0, "R8 sideband unchanged",
          int'({sb_test, sb_rst}), int'({st0, sr0}));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(rsp_valid === 1'b0, "R7 response taken", int'(rsp_valid), 0);
  endtask

  task automatic side_cmd(input logic t, input logic r);
    @(negedge clk);
    cmd_sb_only = 1'b1; cmd_sb_test = t; cmd_sb_rst = r;
    cmd_tms = 1'b1; cmd_tdi = 1'b1; cmd_capture = 1'b1;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_sb_only = 1'b0;
    check(sb_test === t && sb_rst === r, "R8 sideband set",
          int'({sb_test, sb_rst}), int'({t, r}));
    check(cmd_ready === 1'b1 && wire_clk === 1'b1 && wire_oe === 1'b0,
          "R8 no slots", int'({cmd_ready, wire_clk, wire_oe}), 3'b110);
  endtask

  initial begin
    rst_n = 1'b0;
    qlen = '0; cmd_valid = 1'b0; cmd_sb_only = 1'b0;
    cmd_tms = 1'b0; cmd_tdi = 1'b0; cmd_tck_pre = 1'b0; cmd_tck_post = 1'b0;
    cmd_rti = 1'b0; cmd_capture = 1'b0; cmd_sb_test = 1'b0; cmd_sb_rst = 1'b0;
    rsp_ready = 1'b0; wire_di = 1'b0;
    repeat (3) @(negedge clk);
    check(wire_clk === 1'b1 && wire_oe === 1'b0, "R9 wire idle in reset",
          int'({wire_clk, wire_oe}), 2'b10);
    check(rsp_valid === 1'b0, "R9 no response in reset", int'(rsp_valid), 0);
    check(sb_test === 1'b0 && sb_rst === 1'b0, "R9 sideband low in reset",
          int'({sb_test, sb_rst}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd_ready === 1'b1, "R9 ready after reset", int'(cmd_ready), 1);

    side_cmd(1'b1, 1'b0);
    side_cmd(1'b0, 1'b1);
    side_cmd(1'b1, 1'b1);

    for (int qp = 0; qp < 4; qp++) begin
      for (int idx = 0; idx < 64; idx++) begin
        logic [5:0] v;
        v = 6'(idx);
        run_cmd(v[0], v[1], v[2], v[3], v[4], v[5], qp, v[0] ^ v[3] ^ v[5] ^ qp[0]);
      end
    end

    run_cmd(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 2, 1'b1);

    // R1: a pending response blocks the next command
    @(negedge clk);
    qlen = QW'(1);
    cmd_sb_only = 1'b0; cmd_rti = 1'b0; cmd_capture = 1'b1;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k < 12; k++) begin
      wire_di = (k == 10) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    for (int k = 0; k < 5; k++) @(negedge clk);
    check(cmd_ready === 1'b0, "R1 ready low while response pending", int'(cmd_ready), 0);
    check(rsp_valid === 1'b1 && rsp_tdo === 1'b0, "R7 response held",
          int'({rsp_valid, rsp_tdo}), 2'b10);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check(cmd_ready === 1'b1, "R1 ready after response taken", int'(cmd_ready), 1);

    side_cmd(1'b0, 1'b0);

    done = 1;
    finish_run();
  end
endmodule